// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block presents a signed three-digit reading on a single shared 4-bit BCD bus, one digit at a time, together with three active-low strobes that mark which digit position (most, next or least significant) the bus currently carries. A downstream decoder or latch uses each strobe to pick the digit off the bus. The minus sign and both out-of-range conditions are carried on the same bus as reserved codes, so no separate status lines are needed.

A free-running scan walks the positions in a fixed order, holding each strobe low for a programmable number of clocks and inserting a one-clock blanking gap with every strobe high between positions. The bus value only moves during a gap, so it is settled for the whole time a strobe is low. The reading is sampled once per scan, at the gap in front of the most significant position, so a scan never shows digits from two different readings.

Reset is asynchronous and active-low. Its release passes through a two-stage synchronizer, so the scan begins on the third rising clock edge after `rst_n` rises.

Top module: `digit_scan_mux`

## Requirements
- R1: While reset is applied, and until the first gap of the scan, all three strobes are high and the bus is 0000. The first gap begins on the third rising edge after `rst_n` rises.
- R2: The strobes are active-low, and no more than one strobe is low in any cycle.
- R3: A reading from 0 to 999 with neither flag set shows its hundreds, tens and ones in plain BCD at the most, next and least significant positions.
- R4: A reading from -1 to -99 with neither flag set shows code 1010 at the most significant position and the tens and ones of its magnitude at the next and least significant positions.
- R5: When the reading is above 999 or the over flag is set, every position shows code 1011. This takes priority over R6.
- R6: When R5 does not apply and the reading is below -99 or the under flag is set, every position shows code 1010.
- R7: The strobes go low in the order most, next, least significant, and then repeat. Each strobe is low for `slot_len` consecutive clocks, where a value of 0 counts as 1. After each strobe there is exactly one clock with all strobes high.
- R8: `slot_len` is sampled on the edge that opens a slot. A change to it takes effect at the next slot.
- R9: The bus changes only on the edge that opens a gap, so it keeps its value while any strobe is low.
- R10: The reading and flags are taken only on the edge that opens the gap before the most significant position. Changes at any other time do not appear on the bus until the next scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_len | input | LEN_W | Clocks per strobe; 0 is treated as 1 |
| rd_value | input | VAL_W | Signed reading (two's complement) |
| rd_over | input | 1 | Forces the positive out-of-range display |
| rd_under | input | 1 | Forces the negative out-of-range display |
| bcd | output | 4 | Shared digit bus |
| msd_sel_n | output | 1 | Most significant position strobe, active-low |
| nsd_sel_n | output | 1 | Next significant position strobe, active-low |
| lsd_sel_n | output | 1 | Least significant position strobe, active-low |

## Verification
The hardest situation to reach from the ports is an input change that lands exactly on an edge the design treats specially. One case is a new reading arriving on the capture edge itself. The other is `slot_len` changing on the edge that opens a slot, or in the middle of a slot. With long slots these edges are rare. The stimulus therefore keeps slot lengths between 0 and 6 and redraws the reading, the flags and `slot_len` in dense random bursts, so that capture edges and slot-opening edges often coincide with a change. Directed steps also change the reading while the most significant strobe is low and hold values at the range edges (999/1000, -99/-100, -1/0) for whole scans.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  localparam logic [3:0] CODE_MINUS = 4'b1010;
  localparam logic [3:0] CODE_OVER  = 4'b1011;
  localparam int unsigned NUM_POS   = 3;

  typedef enum logic [1:0] {
    POS_MSD = 2'd0,
    POS_NSD = 2'd1,
    POS_LSD = 2'd2
  } digit_pos_t;

  typedef struct packed {
    logic [3:0] msd;
    logic [3:0] nsd;
    logic [3:0] lsd;
  } digit_codes_t;

endpackage

// File: rtl/dsm_bin2bcd.sv
module dsm_bin2bcd #(
  parameter int unsigned BIN_W = 11
) (
  input  logic [BIN_W-1:0] bin,
  output logic [3:0]       hund,
  output logic [3:0]       tens,
  output logic [3:0]       ones
);

  localparam int unsigned NDIG  = 3;
  localparam int unsigned ACC_W = 4 * NDIG;

  logic [ACC_W-1:0] acc;

  // shift-and-add-3; only exact for inputs below 1000
  always_comb begin
    acc = '0;
    for (int i = BIN_W - 1; i >= 0; i--) begin
      for (int d = 0; d < NDIG; d++) begin
        if (acc[4*d +: 4] >= 4'd5) begin
          acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
        end
      end
      acc = {acc[ACC_W-2:0], bin[i]};
    end
  end

  assign ones = acc[3:0];
  assign tens = acc[7:4];
  assign hund = acc[11:8];

endmodule

// File: rtl/dsm_encoder.sv
module dsm_encoder
  import dsm_pkg::*;
#(
  parameter int unsigned VAL_W = 11
) (
  input  logic signed [VAL_W-1:0] value,
  input  logic                    over,
  input  logic                    under,
  output digit_codes_t            codes
);

  localparam int MAX_POS = 999;
  localparam int MIN_NEG = -99;

  logic                    pos_ovr;
  logic                    neg_ovr;
  logic                    minus;
  logic signed [VAL_W-1:0] negated;
  logic        [VAL_W-1:0] mag;
  logic [3:0]              d_h;
  logic [3:0]              d_t;
  logic [3:0]              d_o;

  always_comb begin
    pos_ovr = over || (value > MAX_POS);
    neg_ovr = !pos_ovr && (under || (value < MIN_NEG));
    minus   = value[VAL_W-1];
    negated = -value;
    mag     = minus ? negated : value;
  end

  dsm_bin2bcd #(.BIN_W(VAL_W)) u_b2b (
    .bin  (mag),
    .hund (d_h),
    .tens (d_t),
    .ones (d_o)
  );

  always_comb begin
    if (pos_ovr) begin
      codes = '{msd: CODE_OVER, nsd: CODE_OVER, lsd: CODE_OVER};
    end else if (neg_ovr) begin
      codes = '{msd: CODE_MINUS, nsd: CODE_MINUS, lsd: CODE_MINUS};
    end else if (minus) begin
      codes = '{msd: CODE_MINUS, nsd: d_t, lsd: d_o};
    end else begin
      codes = '{msd: d_h, nsd: d_t, lsd: d_o};
    end
  end

endmodule

// File: rtl/dsm_scan_ctl.sv
module dsm_scan_ctl
  import dsm_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] slot_len,
  output logic             enter_gap,
  output logic             enter_slot,
  output digit_pos_t       gap_pos,
  output digit_pos_t       slot_pos
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic             in_gap_q, in_gap_d;
  digit_pos_t       pos_q, pos_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             slot_last;
  digit_pos_t       pos_nxt;

  always_comb begin
    slot_last = !in_gap_q && (cnt_q == (len_q - LEN_ONE));
    pos_nxt   = (pos_q == POS_LSD) ? POS_MSD : digit_pos_t'(pos_q + 2'd1);

    in_gap_d = in_gap_q;
    pos_d    = pos_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    if (in_gap_q) begin
      in_gap_d = 1'b0;
      cnt_d    = '0;
      len_d    = (slot_len == '0) ? LEN_ONE : slot_len;
    end else if (slot_last) begin
      in_gap_d = 1'b1;
      pos_d    = pos_nxt;
    end else begin
      cnt_d    = cnt_q + LEN_ONE;
    end
  end

  // reset state stands for "last clock of the least significant slot"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_gap_q <= 1'b0;
      pos_q    <= POS_LSD;
      cnt_q    <= '0;
      len_q    <= LEN_ONE;
    end else begin
      in_gap_q <= in_gap_d;
      pos_q    <= pos_d;
      cnt_q    <= cnt_d;
      len_q    <= len_d;
    end
  end

  assign enter_gap  = slot_last;
  assign enter_slot = in_gap_q;
  assign gap_pos    = pos_nxt;
  assign slot_pos   = pos_q;

endmodule

// File: rtl/digit_scan_mux.sv
module digit_scan_mux
  import dsm_pkg::*;
#(
  parameter int unsigned VAL_W = 11,
  parameter int unsigned LEN_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LEN_W-1:0]        slot_len,
  input  logic signed [VAL_W-1:0] rd_value,
  input  logic                    rd_over,
  input  logic                    rd_under,
  output logic [3:0]              bcd,
  output logic                    msd_sel_n,
  output logic                    nsd_sel_n,
  output logic                    lsd_sel_n
);

  localparam logic [NUM_POS-1:0] SEL_IDLE = '1;
  localparam logic [NUM_POS-1:0] SEL_ONE  = NUM_POS'(1);

  // reset release synchronizer
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic       enter_gap;
  logic       enter_slot;
  digit_pos_t gap_pos;
  digit_pos_t slot_pos;

  dsm_scan_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .slot_len   (slot_len),
    .enter_gap  (enter_gap),
    .enter_slot (enter_slot),
    .gap_pos    (gap_pos),
    .slot_pos   (slot_pos)
  );

  // reading snapshot, taken at the gap in front of the MSD slot
  logic                    cap_en;
  logic signed [VAL_W-1:0] val_q;
  logic                    over_q;
  logic                    under_q;
  logic signed [VAL_W-1:0] enc_val;
  logic                    enc_over;
  logic                    enc_under;
  digit_codes_t            codes;

  assign cap_en = enter_gap && (gap_pos == POS_MSD);

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      val_q   <= '0;
      over_q  <= 1'b0;
      under_q <= 1'b0;
    end else if (cap_en) begin
      val_q   <= rd_value;
      over_q  <= rd_over;
      under_q <= rd_under;
    end
  end

  // bypass so the MSD code comes from the value being captured
  always_comb begin
    enc_val   = cap_en ? rd_value : val_q;
    enc_over  = cap_en ? rd_over  : over_q;
    enc_under = cap_en ? rd_under : under_q;
  end

  dsm_encoder #(.VAL_W(VAL_W)) u_enc (
    .value (enc_val),
    .over  (enc_over),
    .under (enc_under),
    .codes (codes)
  );

  // output registers
  logic [3:0]         bcd_q, bcd_d;
  logic [NUM_POS-1:0] sel_q, sel_d;

  always_comb begin
    bcd_d = bcd_q;
    sel_d = sel_q;
    if (enter_gap) begin
      sel_d = SEL_IDLE;
      case (gap_pos)
        POS_MSD: bcd_d = codes.msd;
        POS_NSD: bcd_d = codes.nsd;
        default: bcd_d = codes.lsd;
      endcase
    end else if (enter_slot) begin
      sel_d = ~(SEL_ONE << slot_pos);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      bcd_q <= '0;
      sel_q <= SEL_IDLE;
    end else begin
      bcd_q <= bcd_d;
      sel_q <= sel_d;
    end
  end

  assign bcd       = bcd_q;
  assign msd_sel_n = sel_q[POS_MSD];
  assign nsd_sel_n = sel_q[POS_NSD];
  assign lsd_sel_n = sel_q[POS_LSD];

endmodule

// File: rtl/dsm_checker.sv
module dsm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] bcd,
  input logic       msd_sel_n,
  input logic       nsd_sel_n,
  input logic       lsd_sel_n
);

  logic [2:0] sel_n;
  logic [2:0] last_q;
  logic       seen_q;
  logic [2:0] follow;

  assign sel_n = {lsd_sel_n, nsd_sel_n, msd_sel_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 3'b111;
      seen_q <= 1'b0;
    end else if (sel_n != 3'b111) begin
      last_q <= sel_n;
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    case (last_q)
      3'b110:  follow = 3'b101;
      3'b101:  follow = 3'b011;
      default: follow = 3'b110;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n) <= 1);  // R2

  AST_GAP_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_n) != 3'b111 && sel_n != 3'b111) |-> sel_n == $past(sel_n));  // R7

  AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(sel_n) == 3'b111 && sel_n != 3'b111) |-> sel_n == follow);  // R7

  AST_BUS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n != 3'b111) |-> $stable(bcd));  // R9

  AST_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bcd <= 4'b1011);  // R5

endmodule

bind digit_scan_mux dsm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bcd       (bcd),
  .msd_sel_n (msd_sel_n),
  .nsd_sel_n (nsd_sel_n),
  .lsd_sel_n (lsd_sel_n)
);

// File: tb/digit_scan_mux_bench.sv
module digit_scan_mux_bench;

  localparam int VAL_W = 11;
  localparam int LEN_W = 8;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [LEN_W-1:0]        slot_len;
  logic signed [VAL_W-1:0] rd_value;
  logic                    rd_over;
  logic                    rd_under;
  logic [3:0]              bcd;
  logic                    msd_sel_n, nsd_sel_n, lsd_sel_n;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  digit_scan_mux #(.VAL_W(VAL_W), .LEN_W(LEN_W)) u_digit_scan_mux (
    .clk(clk), .rst_n(rst_n), .slot_len(slot_len), .rd_value(rd_value),
    .rd_over(rd_over), .rd_under(rd_under), .bcd(bcd),
    .msd_sel_n(msd_sel_n), .nsd_sel_n(nsd_sel_n), .lsd_sel_n(lsd_sel_n)
  );

  // expected code for position d (0 MSD, 1 NSD, 2 LSD): R3..R6
  function automatic logic [3:0] ref_code(int v, bit hi, bit lo, int d);
    int m;
    if (hi || v > 999) return 4'hB;
    if (lo || v < -99) return 4'hA;
    if (v < 0) begin
      if (d == 0) return 4'hA;
      m = -v;
    end else begin
      m = v;
    end
    case (d)
      0:       return 4'(m / 100);
      1:       return 4'((m / 10) % 10);
      default: return 4'(m % 10);
    endcase
  endfunction

  function automatic string ref_tag(int v, bit hi, bit lo);
    if (hi || v > 999) return "R5";
    if (lo || v < -99) return "R6";
    if (v < 0) return "R4";
    return "R3";
  endfunction

  // timing expectation from R1, R7, R8, R10
  logic [1:0] m_rs;
  bit         m_gap;
  int         m_idx, m_cnt, m_len;
  int         m_v;
  bit         m_hi, m_lo;
  logic [2:0] exp_sel;
  logic [3:0] exp_bcd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs <= 2'b00; m_gap <= 1'b0; m_idx <= 2; m_cnt <= 0; m_len <= 1;
      m_v <= 0; m_hi <= 1'b0; m_lo <= 1'b0;
      exp_sel <= 3'b111; exp_bcd <= 4'h0;
    end else if (!m_rs[1]) begin
      m_rs <= {m_rs[0], 1'b1};
    end else if (m_gap) begin
      m_gap   <= 1'b0;
      m_cnt   <= 0;
      m_len   <= (slot_len == 0) ? 1 : int'(slot_len);
      exp_sel <= ~(3'b001 << m_idx);
    end else if (m_cnt == m_len - 1) begin
      int nidx;
      nidx = (m_idx == 2) ? 0 : m_idx + 1;
      m_gap   <= 1'b1;
      m_idx   <= nidx;
      exp_sel <= 3'b111;
      if (nidx == 0) begin
        m_v <= int'(rd_value); m_hi <= rd_over; m_lo <= rd_under;
        exp_bcd <= ref_code(int'(rd_value), rd_over, rd_under, 0);
      end else begin
        exp_bcd <= ref_code(m_v, m_hi, m_lo, nidx);
      end
    end else begin
      m_cnt <= m_cnt + 1;
    end
  end

  // comparison, away from the active edge
  logic [3:0] prev_bcd;
  always @(negedge clk) begin
    if (!done) begin
      logic [2:0] got_sel;
      string tg;
      got_sel = {lsd_sel_n, nsd_sel_n, msd_sel_n};
      tg = (!rst_n || !m_rs[1]) ? "R1" : ref_tag(m_v, m_hi, m_lo);
      if (int'(rd_value) != m_v || rd_over != m_hi || rd_under != m_lo) tg = {tg, "/R10"};
      n_cmp++;
      if (got_sel !== exp_sel) begin
        n_bad++;
        $display("FAIL %s strobes got %b expected %b at cycle %0d",
                 ($countones(~got_sel) > 1) ? "R2" : "R7/R8", got_sel, exp_sel, cyc);
      end
      n_cmp++;
      if (bcd !== exp_bcd) begin
        n_bad++;
        $display("FAIL %s bus got %h expected %h at cycle %0d", tg, bcd, exp_bcd, cyc);
      end
      if (got_sel != 3'b111 && rst_n) begin  // R9
        n_cmp++;
        if (bcd !== prev_bcd) begin
          n_bad++;
          $display("FAIL R9 bus moved under strobe got %h expected %h", bcd, prev_bcd);
        end
      end
      prev_bcd = bcd;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired: got cycle %0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic put(int v, bit hi, bit lo);
    rd_value = VAL_W'(v); rd_over = hi; rd_under = lo;
  endtask

  task automatic hold_scans(int n);
    repeat (n * 3 * ((slot_len == 0 ? 1 : int'(slot_len)) + 1) + 4) @(negedge clk);
  endtask

  initial begin
    int dir_vals [14] = '{0, 5, 42, 100, 999, 1000, 1023, -1, -9, -99, -100, -1024, 507, 60};
    void'($urandom(32'd20240611));
    rst_n = 1'b0; slot_len = 8'd3; put(0, 0, 0);
    repeat (4) @(negedge clk);                    // R1 checked during reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);                    // R1 still idle during sync

    // directed readings, each held for two scans: R3 R4 R5 R6
    foreach (dir_vals[i]) begin
      put(dir_vals[i], 0, 0);
      hold_scans(2);
    end
    put(12, 1, 0); hold_scans(2);                 // R5 flag
    put(12, 0, 1); hold_scans(2);                 // R6 flag
    put(-5, 1, 1); hold_scans(2);                 // R5 priority over R6

    // slot length corners: R7 R8
    slot_len = 8'd0; put(321, 0, 0); hold_scans(2);
    slot_len = 8'd1; hold_scans(2);
    slot_len = 8'd6; hold_scans(1);
    @(negedge clk); slot_len = 8'd2;              // mid-slot change, R8
    hold_scans(2);

    // change reading while the MSD strobe is low: R10
    slot_len = 8'd4; put(111, 0, 0); hold_scans(1);
    while (msd_sel_n) @(negedge clk);
    put(-88, 0, 0);
    hold_scans(2);

    // constrained random bursts
    for (int k = 0; k < 30000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) begin
        case ($urandom_range(0, 9))
          0: rd_value = 11'sd999;
          1: rd_value = 11'sd1000;
          2: rd_value = -11'sd99;
          3: rd_value = -11'sd100;
          4: rd_value = -11'sd1;
          5: rd_value = 11'sd0;
          6: rd_value = VAL_W'($urandom_range(0, 2047));
          default: rd_value = VAL_W'(int'($urandom_range(0, 1098)) - 99);
        endcase
        rd_over  = ($urandom_range(0, 15) == 0);
        rd_under = ($urandom_range(0, 15) == 0);
      end
      if ($urandom_range(0, 40) == 0) slot_len = LEN_W'($urandom_range(0, 6));
    end
    hold_scans(1);
    finish_run();
  end

endmodule